// File: doc/BRIEF.md
# Serial/Byte Input Front End for a 16-bit DAC

This block is the digital front end of a 16-bit digital-to-analog converter. It runs on one system clock, and it treats every strobe input as an enable that is sampled on the rising clock edge. A code reaches it in one of two ways, picked by a mode input. It can arrive as two 8-bit bytes on an 8-bit data bus. It can also arrive as a 16-bit serial stream. In serial mode, two bus bits change role: bit 0 carries the serial data and bit 1 picks the shift direction.

The code is double-buffered. Writes go into an input latch first. A separate load strobe then copies that latch into the DAC latch, which drives the converter code. Because of this, several devices on shared control lines can take their codes one at a time and then all update together. A serial output carries the bit pushed out of the input latch on each shift, so devices can be chained. A clear input forces the converter code to zero volts at once. The zero is either unipolar zero or bipolar (offset-binary) zero, and the low-byte enable picks which one while clear is high.

Top module: `dacfe_top`

## Requirements
- R1: After reset, the input latch and the DAC latch both hold 0x0000, `dac_code` reads 0x0000 and `ser_out` is 0.
- R2: In byte mode (`serial_mode`=0), a clock with `sel`=1 and `hi_en`=1 writes `din` into input bits 15:8. A clock with `sel`=1 and `lo_en`=1 writes `din` into bits 7:0. The other half is left unchanged, so the two bytes can be written in either order.
- R3: When `sel`=0, the input latch and `ser_out` do not change, whatever the other write inputs are.
- R4: In serial mode with `din[1]`=1 (MSB first), each clock with `sel`=1 shifts the input latch one place toward bit 15 and puts `din[0]` into bit 0. Sixteen such strobes load a word sent from bit 15 down to bit 0.
- R5: In serial mode with `din[1]`=0 (LSB first), each clock with `sel`=1 shifts the input latch one place toward bit 0 and puts `din[0]` into bit 15. Sixteen such strobes load a word sent from bit 0 up to bit 15.
- R6: On each serial shift, `ser_out` becomes the bit that was pushed out: old bit 15 when shifting MSB first, old bit 0 when shifting LSB first. It holds its value on every other clock.
- R7: A clock with `load`=1 and `clr`=0 copies the input latch, as it stood before that edge, into the DAC latch. It does not change the input latch. With neither `load` nor `clr` set, the DAC latch holds.
- R8: While `clr`=1, `dac_code` reads the zero code without waiting for a clock edge: 0x8000 (bipolar zero) if `lo_en`=1, 0x0000 (unipolar zero) if `lo_en`=0. The DAC latch takes that code at the edge and keeps it after `clr` falls.
- R9: `clr` has priority over `load`. When both are 1, the DAC latch takes the zero code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_mode | input | 1 | 1 = serial loading, 0 = byte loading |
| sel | input | 1 | Chip-select write strobe, sampled each clock |
| hi_en | input | 1 | High-byte write enable (byte mode) |
| lo_en | input | 1 | Low-byte write enable; zero-type select while clearing |
| din | input | 8 | Byte data; bit 0 = serial data, bit 1 = shift direction in serial mode |
| load | input | 1 | Copies the input latch into the DAC latch |
| clr | input | 1 | Forces the DAC code to zero (asynchronous at the output) |
| dac_code | output | 16 | Code driven to the converter |
| ser_out | output | 1 | Bit shifted out of the input latch, for chaining |

## Verification
The assertions check, on every clock, that the input latch holds when `sel` is low. They check each serial shift in both directions, including the bit that moves to `ser_out`. They check that the DAC latch either holds, takes the pre-edge input word on a load, or takes the zero code that `lo_en` picks during a clear. Several things show only in the bench scenarios: the full 16-strobe word assembly, both byte orders, the chained bit sequence at `ser_out` while a second word is shifted in, the zero appearing at `dac_code` before any clock edge, and the input latch surviving a clear (seen by loading it again afterwards).

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic {
        DIR_LSB_FIRST = 1'b0,
        DIR_MSB_FIRST = 1'b1
    } shift_dir_e;

    typedef enum logic {
        ZERO_UNIPOLAR = 1'b0,
        ZERO_BIPOLAR  = 1'b1
    } zero_kind_e;
endpackage

// File: rtl/dacfe_input_latch.sv
module dacfe_input_latch
    import dacfe_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   serial_mode,
    input  logic                   sel,
    input  logic                   hi_en,
    input  logic                   lo_en,
    input  logic [WIDTH/2-1:0]     din,
    output logic [WIDTH-1:0]       word_q,
    output logic                   ser_out
);
    localparam int HALF = WIDTH / 2;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             so;
    } state_t;

    state_t     st_d, st_q;
    shift_dir_e dir;

    assign dir = shift_dir_e'(din[1]);

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (serial_mode) begin
                if (dir == DIR_MSB_FIRST) begin
                    st_d.so   = st_q.word[WIDTH-1];
                    st_d.word = {st_q.word[WIDTH-2:0], din[0]};
                end else begin
                    st_d.so   = st_q.word[0];
                    st_d.word = {din[0], st_q.word[WIDTH-1:1]};
                end
            end else begin
                if (hi_en) st_d.word[WIDTH-1:HALF] = din;
                if (lo_en) st_d.word[HALF-1:0]     = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q  = st_q.word;
    assign ser_out = st_q.so;

    // R3: no strobe, no change
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(word_q) && $stable(ser_out)));

    // R4 / R6: MSB-first shift
    p_msb_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && serial_mode && din[1]) |=>
        (word_q[WIDTH-1:1] == $past(word_q[WIDTH-2:0])) && (word_q[0] == $past(din[0])));
    p_msb_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && serial_mode && din[1]) |=> (ser_out == $past(word_q[WIDTH-1])));

    // R5 / R6: LSB-first shift
    p_lsb_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && serial_mode && !din[1]) |=>
        (word_q[WIDTH-2:0] == $past(word_q[WIDTH-1:1])) && (word_q[WIDTH-1] == $past(din[0])));
    p_lsb_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && serial_mode && !din[1]) |=> (ser_out == $past(word_q[0])));

    // R6: byte writes leave the chain output alone
    p_byte_so_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !serial_mode) |=> $stable(ser_out));
endmodule

// File: rtl/dacfe_dac_latch.sv
module dacfe_dac_latch
    import dacfe_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  logic             zero_sel,
    input  logic [WIDTH-1:0] in_word,
    output logic [WIDTH-1:0] dac_code
);
    localparam logic [WIDTH-1:0] BIPOLAR_ZERO  = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] UNIPOLAR_ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] code;
    } state_t;

    state_t           st_d, st_q;
    zero_kind_e       kind;
    logic [WIDTH-1:0] zero_code;

    assign kind      = zero_kind_e'(zero_sel);
    assign zero_code = (kind == ZERO_BIPOLAR) ? BIPOLAR_ZERO : UNIPOLAR_ZERO;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.code = zero_code;
        else if (load) st_d.code = in_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // clear reaches the converter without waiting for an edge
    assign dac_code = clr ? zero_code : st_q.code;

    p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (st_q.code == $past(in_word)));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(st_q.code));
    // R8 and R9: zero code wins, whatever load does
    p_clr_bipolar_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && zero_sel) |=> (st_q.code == BIPOLAR_ZERO));
    p_clr_unipolar_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !zero_sel) |=> (st_q.code == UNIPOLAR_ZERO));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top #(
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 serial_mode,
    input  logic                 sel,
    input  logic                 hi_en,
    input  logic                 lo_en,
    input  logic [WIDTH/2-1:0]   din,
    input  logic                 load,
    input  logic                 clr,
    output logic [WIDTH-1:0]     dac_code,
    output logic                 ser_out
);
    logic [WIDTH-1:0] in_word;

    dacfe_input_latch #(.WIDTH(WIDTH)) u_in (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .sel(sel),
        .hi_en(hi_en), .lo_en(lo_en), .din(din),
        .word_q(in_word), .ser_out(ser_out)
    );

    dacfe_dac_latch #(.WIDTH(WIDTH)) u_dac (
        .clk(clk), .rst_n(rst_n), .load(load), .clr(clr),
        .zero_sel(lo_en), .in_word(in_word), .dac_code(dac_code)
    );
endmodule

// File: tb/dacfe_top_bench.sv
module dacfe_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serial_mode = 1'b0, sel = 1'b0, hi_en = 1'b0, lo_en = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        load = 1'b0, clr = 1'b0;
    logic [15:0] dac_code;
    logic        ser_out;

    int          n_chk = 0, n_fail = 0;
    logic [15:0] m_in = 16'h0, m_dac = 16'h0;
    logic        m_so = 1'b0;

    always #4 clk = ~clk;

    dacfe_top u_dacfe_top (
        .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .sel(sel),
        .hi_en(hi_en), .lo_en(lo_en), .din(din), .load(load), .clr(clr),
        .dac_code(dac_code), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] zero_of(input logic bip);
        return bip ? 16'h8000 : 16'h0000;
    endfunction

    // one clock: drive at negedge, update model from the requirements after the edge
    task automatic cyc(input logic sm, input logic s, input logic h, input logic l,
                       input logic [7:0] d, input logic ld, input logic c);
        @(negedge clk);
        serial_mode = sm; sel = s; hi_en = h; lo_en = l; din = d; load = ld; clr = c;
        @(posedge clk);
        #1;
        if (c)       m_dac = zero_of(l);
        else if (ld) m_dac = m_in;
        if (s) begin
            if (sm) begin
                if (d[1]) begin m_so = m_in[15]; m_in = {m_in[14:0], d[0]}; end
                else      begin m_so = m_in[0];  m_in = {d[0], m_in[15:1]}; end
            end else begin
                if (h) m_in[15:8] = d;
                if (l) m_in[7:0]  = d;
            end
        end
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic do_load();
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic shift_word(input logic [15:0] w, input logic msb, input logic [15:0] prev,
                              input bit check_out);
        for (int k = 0; k < 16; k++) begin
            int idx = msb ? 15 - k : k;
            cyc(1'b1, 1'b1, 1'b0, 1'b0, {6'b0, msb, w[idx]}, 1'b0, 1'b0);
            if (check_out) chk("R6 chained bit", {31'b0, ser_out}, {31'b0, prev[idx]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0D1C));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 dac_code in reset", {16'b0, dac_code}, 32'h0);
        chk("R1 ser_out in reset", {31'b0, ser_out}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        chk("R1 dac_code after reset", {16'b0, dac_code}, 32'h0);
        chk("R1 ser_out after reset", {31'b0, ser_out}, 32'h0);

        // R2: high byte then low byte
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0);
        chk("R7 no load yet", {16'b0, dac_code}, 32'h0);
        do_load();
        chk("R2 high-then-low", {16'b0, dac_code}, 32'hA53C);
        // R2: low first then high, other half kept
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h12, 1'b0, 1'b0);
        do_load();
        chk("R2 low-then-high", {16'b0, dac_code}, 32'h1277);

        // R3: writes without sel ignored
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b0);
        do_load();
        chk("R3 unselected write ignored", {16'b0, dac_code}, 32'h1277);
        chk("R3 ser_out unchanged", {31'b0, ser_out}, 32'h0);

        // R7: load with same-cycle write takes old input word
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'hEE, 1'b1, 1'b0);
        chk("R7 load sees pre-edge word", {16'b0, dac_code}, 32'h1277);
        do_load();
        chk("R7 second load", {16'b0, dac_code}, 32'hEE77);

        // R8: asynchronous bipolar clear, visible before the edge
        @(negedge clk); clr = 1'b1; lo_en = 1'b1; sel = 1'b0; load = 1'b0;
        #1;
        chk("R8 bipolar zero before edge", {16'b0, dac_code}, 32'h8000);
        @(posedge clk); #1; m_dac = 16'h8000;
        idle();
        chk("R8 bipolar zero held", {16'b0, dac_code}, 32'h8000);
        @(negedge clk); clr = 1'b1; lo_en = 1'b0;
        #1;
        chk("R8 unipolar zero before edge", {16'b0, dac_code}, 32'h0000);
        @(posedge clk); #1; m_dac = 16'h0000;
        idle();
        chk("R8 unipolar zero held", {16'b0, dac_code}, 32'h0000);
        // clear left input latch intact
        do_load();
        chk("R7 input latch survives clear", {16'b0, dac_code}, 32'hEE77);

        // R9: clear beats load
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1);
        idle();
        chk("R9 clr over load", {16'b0, dac_code}, 32'h8000);

        // R4: MSB-first serial word
        shift_word(16'h1234, 1'b1, 16'h0, 1'b0);
        do_load();
        chk("R4 msb-first word", {16'b0, dac_code}, 32'h1234);
        // R6: second word pushes the first out, MSB first
        shift_word(16'hC3A9, 1'b1, 16'h1234, 1'b1);
        do_load();
        chk("R4 second msb word", {16'b0, dac_code}, 32'hC3A9);

        // R5: LSB-first serial word, chained bits come out LSB first
        shift_word(16'hBEEF, 1'b0, 16'hC3A9, 1'b1);
        idle();
        chk("R6 ser_out holds when idle", {31'b0, ser_out}, {31'b0, m_so});
        do_load();
        chk("R5 lsb-first word", {16'b0, dac_code}, 32'hBEEF);

        // random stimulus against the bench model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            cyc(r[0], r[1], r[2], r[3], r[15:8], r[4] & r[5], (r[7:6] == 2'b11) & r[16]);
            chk("R7 random dac_code", {16'b0, dac_code}, {16'b0, m_dac});
            chk("R6 random ser_out", {31'b0, ser_out}, {31'b0, m_so});
        end
        idle();
        do_load();
        chk("R2 random final input word", {16'b0, dac_code}, {16'b0, m_in});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule